// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two predictors run side by side. The global path indexes a table of 2-bit counters with a shift register that holds the outcomes of the most recent conditional branches. The local path keeps a short outcome history for each tracked branch, and that history indexes a table of 3-bit counters. A chooser table, indexed by branch address, learns for each branch which of the two paths has been more accurate. The final prediction comes from the path the chooser favours.

A fetch stage presents a branch address on the lookup port and receives the prediction in the same cycle. When the branch resolves, the update port receives the address, the real outcome and the two component predictions that were made at lookup. On that clock edge the block trains the counters, shifts both histories and adjusts the chooser. Lookups see the new state from the following cycle onward. All table sizes are set by parameters.

Top module: `tournament_predictor`

## Requirements
- R1: After reset every global counter reads weakly not-taken (01), every local counter reads weakly not-taken (011), every chooser reads weakly global (01) and the global history is zero. Until the first update, all four prediction outputs are 0.
- R2: Lookup is combinational from `lk_pc` and the stored state. An update changes lookups only from the cycle after the clock edge that samples it.
- R3: On each update the global history shifts left by one and takes the resolved outcome into bit 0. `ghist_o` shows the full 12-bit history.
- R4: The global prediction is bit 1 of the 2-bit saturating counter selected by the current global history. An update moves that counter one step toward the outcome, and it stops at 0 or 3.
- R5: Each branch has a 10-bit local history, selected by PC bits [11:2]. An update shifts the outcome into bit 0 of that entry, so addresses that differ only outside bits [11:2] share an entry.
- R6: The local prediction is bit 2 of the 3-bit saturating counter selected by the branch's local history. An update moves that counter one step toward the outcome, and it stops at 0 or 7.
- R7: A chooser counter changes only when the two component predictions differ. It steps up (toward local) when the local prediction matched the outcome, and down (toward global) otherwise, saturating at 0 and 3. `lk_use_local` is its bit 1.
- R8: `lk_taken` equals `lk_loc_pred` when `lk_use_local` is 1, and `lk_glob_pred` otherwise.
- R9: A branch that repeats taken, taken, taken, not-taken is predicted correctly on every outcome once the pattern has been trained.
- R10: A loop-closing branch that is taken repeatedly gives a local prediction of taken after training.
- R11: When `upd_valid` is 0, the other update inputs have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_pc | input | 32 | Address of the branch being looked up |
| lk_taken | output | 1 | Final predicted direction |
| lk_glob_pred | output | 1 | Global-path prediction |
| lk_loc_pred | output | 1 | Local-path prediction |
| lk_use_local | output | 1 | Chooser favours the local path |
| upd_valid | input | 1 | Apply an update on this edge |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_glob_pred | input | 1 | Global prediction made at lookup |
| upd_loc_pred | input | 1 | Local prediction made at lookup |
| ghist_o | output | 12 | Current global outcome history |

## Verification
The bench targets the chooser's disagreement rule. A design that moves the chooser on agreement, or moves it the wrong way, switches paths too early or never leaves the global path, and this shows up in `lk_use_local` and in the final prediction. Counter saturation and the 3-bit local counter width are covered by long runs of one direction followed by reversals. A wrong width or reset value flips the local prediction after the wrong number of updates. The bench also checks history aliasing through PC bits above bit 11, the taken-taken-taken-not-taken pattern, and update inputs that toggle while `upd_valid` is low, which a careless enable would let corrupt the histories.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
   // Chooser decision, carried by the top bit of each chooser counter.
   typedef enum logic {PICK_GLOBAL = 1'b0, PICK_LOCAL = 1'b1} tbp_pick_e;

   // Direction in which a chooser counter is trained.
   function automatic logic toward_local(input logic loc_pred, input logic outcome);
      return loc_pred == outcome;
   endfunction
endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
   parameter int unsigned IDX_W   = 10,
   parameter int unsigned CTR_W   = 2,
   parameter int unsigned RST_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_msb,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up
);
   localparam int unsigned DEPTH = 1 << IDX_W;
   localparam logic [CTR_W-1:0] CMAX = '1;
   localparam logic [CTR_W-1:0] CRST = CTR_W'(RST_VAL);

   if (CTR_W < 1) begin : g_bad_w
      $error("tbp_ctr_table: CTR_W must be at least 1");
   end
   if (RST_VAL > (1 << CTR_W) - 1) begin : g_bad_rst
      $error("tbp_ctr_table: RST_VAL does not fit in CTR_W bits");
   end

   logic [CTR_W-1:0] mem [DEPTH];
   logic [CTR_W-1:0] cur;

   assign rd_msb = mem[rd_idx][CTR_W-1];
   assign cur    = mem[wr_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= CRST;
      end else if (wr_en) begin
         if (wr_up && cur != CMAX)       mem[wr_idx] <= cur + 1'b1;
         else if (!wr_up && cur != '0)   mem[wr_idx] <= cur - 1'b1;
      end
   end
endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
   parameter int unsigned IDX_W  = 10,
   parameter int unsigned HIST_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx_a,
   output logic [HIST_W-1:0] rd_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [HIST_W-1:0] rd_b,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_bit
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [HIST_W-1:0] mem [DEPTH];
   logic [HIST_W-1:0] nxt;

   assign rd_a = mem[rd_idx_a];
   assign rd_b = mem[rd_idx_b];

   if (HIST_W == 1) begin : g_one
      assign nxt = wr_bit;
   end else begin : g_shift
      assign nxt = {mem[wr_idx][HIST_W-2:0], wr_bit};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= nxt;
      end
   end
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned PC_LSB  = 2,
   parameter int unsigned GHIST_W = 12,
   parameter int unsigned LIDX_W  = 10,
   parameter int unsigned LHIST_W = 10,
   parameter int unsigned GCTR_W  = 2,
   parameter int unsigned LCTR_W  = 3,
   parameter int unsigned CCTR_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PC_W-1:0]    lk_pc,
   output logic               lk_taken,
   output logic               lk_glob_pred,
   output logic               lk_loc_pred,
   output logic               lk_use_local,
   input  logic               upd_valid,
   input  logic [PC_W-1:0]    upd_pc,
   input  logic               upd_taken,
   input  logic               upd_glob_pred,
   input  logic               upd_loc_pred,
   output logic [GHIST_W-1:0] ghist_o
);
   import tbp_pkg::*;

   // Weakly not-taken / weakly global: the value just below the midpoint.
   localparam int unsigned GRST = (1 << (GCTR_W - 1)) - 1;
   localparam int unsigned LRST = (1 << (LCTR_W - 1)) - 1;
   localparam int unsigned CRST = (1 << (CCTR_W - 1)) - 1;

   if (PC_W < PC_LSB + LIDX_W) begin : g_bad_pc
      $error("tournament_predictor: PC_W too narrow for the local index");
   end
   if (GHIST_W < 1 || LHIST_W < 1 || LIDX_W < 1) begin : g_bad_hist
      $error("tournament_predictor: history and index widths must be positive");
   end
   if (GCTR_W < 1 || LCTR_W < 1 || CCTR_W < 1) begin : g_bad_ctr
      $error("tournament_predictor: counter widths must be positive");
   end

   logic [GHIST_W-1:0] ghist;
   logic [LIDX_W-1:0]  lk_idx, up_idx;
   logic [LHIST_W-1:0] lk_lhist, up_lhist;
   tbp_pick_e          pick;
   logic               choose_en;

   assign lk_idx  = lk_pc[PC_LSB +: LIDX_W];
   assign up_idx  = upd_pc[PC_LSB +: LIDX_W];
   assign ghist_o = ghist;

   // Global outcome history.
   if (GHIST_W == 1) begin : g_gh_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         ghist <= '0;
         else if (upd_valid) ghist <= upd_taken;
      end
   end else begin : g_gh_shift
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         ghist <= '0;
         else if (upd_valid) ghist <= {ghist[GHIST_W-2:0], upd_taken};
      end
   end

   tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W), .RST_VAL(GRST)) u_gctr (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(ghist), .rd_msb(lk_glob_pred),
      .wr_en(upd_valid), .wr_idx(ghist), .wr_up(upd_taken)
   );

   tbp_hist_table #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lhist (
      .clk(clk), .rst_n(rst_n),
      .rd_idx_a(lk_idx), .rd_a(lk_lhist),
      .rd_idx_b(up_idx), .rd_b(up_lhist),
      .wr_en(upd_valid), .wr_idx(up_idx), .wr_bit(upd_taken)
   );

   tbp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W), .RST_VAL(LRST)) u_lctr (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_lhist), .rd_msb(lk_loc_pred),
      .wr_en(upd_valid), .wr_idx(up_lhist), .wr_up(upd_taken)
   );

   assign choose_en = upd_valid && (upd_glob_pred != upd_loc_pred);

   tbp_ctr_table #(.IDX_W(LIDX_W), .CTR_W(CCTR_W), .RST_VAL(CRST)) u_choose (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_idx), .rd_msb(lk_use_local),
      .wr_en(choose_en), .wr_idx(up_idx),
      .wr_up(toward_local(upd_loc_pred, upd_taken))
   );

   assign pick     = tbp_pick_e'(lk_use_local);
   assign lk_taken = (pick == PICK_LOCAL) ? lk_loc_pred : lk_glob_pred;
endmodule

// File: rtl/tournament_predictor_chk.sv
module tournament_predictor_chk #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned GHIST_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic [PC_W-1:0]    lk_pc,
   input logic               lk_taken,
   input logic               lk_glob_pred,
   input logic               lk_loc_pred,
   input logic               lk_use_local,
   input logic               upd_valid,
   input logic               upd_pc_any,
   input logic               upd_taken,
   input logic               upd_glob_pred,
   input logic               upd_loc_pred,
   input logic [GHIST_W-1:0] ghist_o
);
   logic seen_upd;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seen_upd <= 1'b0;
      else if (upd_valid) seen_upd <= 1'b1;
   end

   // R1: nothing predicts taken before the first update
   p_quiet_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_upd |-> (!lk_taken && !lk_glob_pred && !lk_loc_pred && !lk_use_local));

   // R3: history shift on update
   p_hist_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> ghist_o == {$past(ghist_o[GHIST_W-2:0]), $past(upd_taken)});

   // R11: no update, no history change
   p_hist_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> $stable(ghist_o));

   // R2: with no update and a steady address, the prediction holds
   p_steady_pred_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> ($stable(lk_pc) -> $stable(lk_taken)));

   // R7: the chooser keeps its value when the components agreed
   p_choose_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_glob_pred == upd_loc_pred) |=> ($stable(lk_pc) -> $stable(lk_use_local)));

   // R8: agreeing components decide the final prediction
   p_final_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_glob_pred == lk_loc_pred) |-> (lk_taken == lk_glob_pred));
endmodule

bind tournament_predictor tournament_predictor_chk #(.PC_W(PC_W), .GHIST_W(GHIST_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
   .lk_glob_pred(lk_glob_pred), .lk_loc_pred(lk_loc_pred), .lk_use_local(lk_use_local),
   .upd_valid(upd_valid), .upd_pc_any(upd_pc[0]), .upd_taken(upd_taken),
   .upd_glob_pred(upd_glob_pred), .upd_loc_pred(upd_loc_pred), .ghist_o(ghist_o)
);

// File: tb/tournament_predictor_test.sv
module tournament_predictor_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_taken, lk_glob_pred, lk_loc_pred, lk_use_local;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0, upd_glob_pred = 1'b0, upd_loc_pred = 1'b0;
   logic [11:0] ghist_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tournament_predictor uut (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
      .lk_glob_pred(lk_glob_pred), .lk_loc_pred(lk_loc_pred), .lk_use_local(lk_use_local),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
      .upd_glob_pred(upd_glob_pred), .upd_loc_pred(upd_loc_pred), .ghist_o(ghist_o)
   );

   // Behavioural reference built from the requirements.
   logic [1:0] m_g [4096];
   logic [2:0] m_l [1024];
   logic [9:0] m_lh [1024];
   logic [1:0] m_c [1024];
   logic [11:0] m_gh;

   function automatic logic [9:0] pidx(input logic [31:0] pc);
      return pc[11:2];
   endfunction

   function automatic logic [1:0] step2(input logic [1:0] v, input logic up);
      if (up)  return (v == 2'd3) ? v : v + 2'd1;
      return (v == 2'd0) ? v : v - 2'd1;
   endfunction

   function automatic logic [2:0] step3(input logic [2:0] v, input logic up);
      if (up)  return (v == 3'd7) ? v : v + 3'd1;
      return (v == 3'd0) ? v : v - 3'd1;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 4096; i++) m_g[i] = 2'd1;
      for (int i = 0; i < 1024; i++) begin
         m_l[i] = 3'd3; m_lh[i] = '0; m_c[i] = 2'd1;
      end
      m_gh = '0;
   endtask

   function automatic logic m_gp();
      return m_g[m_gh][1];
   endfunction
   function automatic logic m_lp(input logic [31:0] pc);
      return m_l[m_lh[pidx(pc)]][2];
   endfunction
   function automatic logic m_ul(input logic [31:0] pc);
      return m_c[pidx(pc)][1];
   endfunction
   function automatic logic m_fin(input logic [31:0] pc);
      return m_ul(pc) ? m_lp(pc) : m_gp();
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      upd_valid = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Present pc and compare all lookup outputs with the reference.
   task automatic look(input string req, input logic [31:0] pc);
      @(negedge clk);
      lk_pc = pc;
      #1;
      chk({req, " glob"}, 32'(lk_glob_pred), 32'(m_gp()));
      chk({req, " loc"}, 32'(lk_loc_pred), 32'(m_lp(pc)));
      chk({req, " choose"}, 32'(lk_use_local), 32'(m_ul(pc)));
      chk({req, " final"}, 32'(lk_taken), 32'(m_fin(pc)));
   endtask

   task automatic do_update(input logic [31:0] pc, input logic t);
      logic gp, lp;
      logic [9:0] ix;
      @(negedge clk);
      gp = m_gp(); lp = m_lp(pc); ix = pidx(pc);
      upd_valid = 1'b1; upd_pc = pc; upd_taken = t;
      upd_glob_pred = gp; upd_loc_pred = lp;
      @(posedge clk);
      #1;
      upd_valid = 1'b0;
      if (gp != lp) m_c[ix] = step2(m_c[ix], lp == t);
      m_g[m_gh] = step2(m_g[m_gh], t);
      m_l[m_lh[ix]] = step3(m_l[m_lh[ix]], t);
      m_lh[ix] = {m_lh[ix][8:0], t};
      m_gh = {m_gh[10:0], t};
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R1 ghist", 32'(ghist_o), 32'h0);
      foreach (m_c[i]) if (i < 3) look("R1", 32'h100 * i + 32'h40);
      chk("R1 final zero", 32'(lk_taken), 32'h0);
   endtask

   task automatic t_ghist_shift();
      logic [11:0] exp_gh = '0;
      do_reset();
      for (int i = 0; i < 14; i++) begin
         do_update(32'h200, (i % 3) == 0);
         exp_gh = {exp_gh[10:0], 1'((i % 3) == 0)};
      end
      @(negedge clk); #1;
      chk("R3 ghist pattern", 32'(ghist_o), 32'(exp_gh));
      // R11: toggle update fields with the valid low
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         upd_pc = 32'h200 + 32'(4 * i); upd_taken = i[0];
         upd_glob_pred = ~i[0]; upd_loc_pred = i[1];
      end
      @(negedge clk); #1;
      chk("R11 ghist held", 32'(ghist_o), 32'(exp_gh));
      look("R11 tables held", 32'h200);
      look("R11 tables held", 32'h204);
   endtask

   task automatic t_disagree();
      do_reset();
      do_update(32'h100, 1'b1);      // agreement: chooser stays
      look("R7 agree keeps global", 32'h100);
      chk("R7 chooser unchanged", 32'(lk_use_local), 32'h0);
      look("R6 local counter taken after one step", 32'h300);
      chk("R6 loc pred", 32'(lk_loc_pred), 32'h1);
      chk("R4 glob pred", 32'(lk_glob_pred), 32'h0);
      chk("R8 final follows global", 32'(lk_taken), 32'h0);
      // Disagreement, local right: before the edge nothing moves
      @(negedge clk);
      lk_pc = 32'h300;
      upd_valid = 1'b1; upd_pc = 32'h300; upd_taken = 1'b1;
      upd_glob_pred = 1'b0; upd_loc_pred = 1'b1;
      #1;
      chk("R2 no effect before edge", 32'(lk_use_local), 32'h0);
      @(posedge clk); #1;
      upd_valid = 1'b0;
      m_c[pidx(32'h300)] = 2'd2;
      m_g[m_gh] = step2(m_g[m_gh], 1'b1);
      m_l[0] = step3(m_l[0], 1'b1);
      m_lh[pidx(32'h300)] = 10'd1;
      m_gh = {m_gh[10:0], 1'b1};
      look("R2 effect after edge", 32'h300);
      chk("R7 toward local", 32'(lk_use_local), 32'h1);
      chk("R8 final follows local", 32'(lk_taken), 32'(lk_loc_pred));
      // Saturation and reversal on several addresses
      for (int i = 0; i < 9; i++) do_update(32'h300, 1'b0);
      for (int i = 0; i < 5; i++) do_update(32'h500, 1'b1);
      for (int i = 0; i < 3; i++) do_update(32'h300, 1'b1);
      look("R4 R6 R7 after runs", 32'h300);
      look("R4 R6 R7 after runs", 32'h500);
      look("R4 R6 R7 after runs", 32'h700);
   endtask

   task automatic t_loop();
      do_reset();
      for (int i = 0; i < 20; i++) do_update(32'h40, 1'b1);
      look("R10 loop branch", 32'h40);
      chk("R10 local taken", 32'(lk_loc_pred), 32'h1);
      chk("R10 final taken", 32'(lk_taken), 32'h1);
      look("R5 alias above bit 11", 32'h1040);
      chk("R5 alias shares history", 32'(lk_loc_pred), 32'h1);
      look("R5 alias low bits", 32'h43);
      do_update(32'h1040, 1'b0);
      look("R5 alias update", 32'h40);
   endtask

   task automatic t_pattern();
      logic [3:0] pat = 4'b0111;
      int miss = 0;
      do_reset();
      for (int i = 0; i < 160; i++) do_update(32'h80, pat[i % 4]);
      for (int i = 0; i < 8; i++) begin
         look("R9 pattern", 32'h80);
         if (lk_taken !== pat[i % 4]) miss++;
         do_update(32'h80, pat[i % 4]);
      end
      chk("R9 pattern misses", 32'(miss), 32'h0);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      t_reset_state();
      t_ghist_shift();
      t_disagree();
      t_loop();
      t_pattern();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule